// File: doc/BRIEF.md
# Dual-Channel System Timer

The block is a memory-mapped timer with two channels. Software reaches it over a simple 32-bit register port. A write is a single cycle with write enable high. A read is a single cycle with read enable high, and the data appears on the next clock.

Channel 1 is a compare timer. It counts up, and when its count equals a programmed compare value it sets a sticky match flag. The flag, gated by a mask bit, drives the single interrupt line. Channel 2 is a free-running 64-bit up-counter that serves as a timebase. Reading its low word captures the upper word into a holding register, so that software gets a coherent 64-bit value from two reads.

Both channels are paced by one reference tick input. Each channel has its own power-of-four prescaler in front of its counter.

Top module: `dual_timer`

## Requirements
- R1: After a synchronous reset, every register reads zero, both channels are stopped, the mask bit is 0 and `irq` is 0.
- R2: Prescale register 0x00 holds the channel-1 code in bits [1:0] and the channel-2 code in bits [3:2]. For code n, the enabled channel advances once every 4^n reference ticks (code 0 gives /1, code 1 gives /4, code 2 gives /16), and code 3 behaves like code 2. The prescaler phase restarts from zero whenever its channel is stopped or cleared.
- R3: Writing 1 to bit 0 of register 0x08 zeroes the channel-1 count, and writing 1 to bit 1 zeroes the channel-2 count. A zero bit leaves its counter alone, and 0x08 reads as zero.
- R4: Writing 1 to bit 0 or bit 1 of register 0x34 starts channel 1 or channel 2. Writing 1 to the same bit of register 0x38 stops that channel. Zero bits written to either register change nothing. Register 0x34 reads back the run state of both channels in bits [1:0].
- R5: Flag bit 0 of register 0x0C becomes 1 on the clock after channel 1 is running with its count equal to the compare value at register 0x14. The flag stays set afterwards.
- R6: Writing 0 to bit 0 of register 0x0C clears the flag, unless the match condition holds in that same cycle. Writing 1 to the bit leaves it unchanged.
- R7: `irq` equals the flag ANDed with the inverse of mask bit 0 of register 0x10, cycle for cycle.
- R8: After a match, channel 1 keeps counting and wraps from all ones to zero. The compare value may be as large as all ones.
- R9: A read of 0x20 returns the low word of channel 2 and copies the upper bits into the buffer at 0x24. A read of 0x24 returns that buffer.
- R10: The compare value, the prescale codes and the mask bit read back as they were written. Register 0x18 returns the channel-1 count, and unmapped addresses read zero.
- R11: A stopped channel holds its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference clock enable feeding both prescalers |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle |
| bus_re | input | 1 | Read strobe, one cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered, valid the clock after `bus_re` |
| irq | output | 1 | Interrupt, registered |

## Verification
The bench builds the timer with a 16-bit data word, a 12-bit channel-1 counter and a 24-bit channel-2 counter. With these sizes, channel 1 wraps with an all-ones compare value, and channel 2 carries out of its low word into the high buffer, both within tens of thousands of cycles. The behavioural model follows reads, flags, the interrupt and both prescaler phases under an irregular reference tick pattern and under every prescale code.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;
  localparam int ADDR_W = 8;
  localparam int CODE_W = 2;
  localparam int PH_W   = 4;

  localparam logic [ADDR_W-1:0] A_PSC = 8'h00;
  localparam logic [ADDR_W-1:0] A_CLR = 8'h08;
  localparam logic [ADDR_W-1:0] A_FLG = 8'h0C;
  localparam logic [ADDR_W-1:0] A_MSK = 8'h10;
  localparam logic [ADDR_W-1:0] A_CMP = 8'h14;
  localparam logic [ADDR_W-1:0] A_C1  = 8'h18;
  localparam logic [ADDR_W-1:0] A_C2L = 8'h20;
  localparam logic [ADDR_W-1:0] A_C2H = 8'h24;
  localparam logic [ADDR_W-1:0] A_ENS = 8'h34;
  localparam logic [ADDR_W-1:0] A_ENC = 8'h38;

  // Last phase value before a step: 4^n - 1, code 3 saturates to /16
  function automatic logic [PH_W-1:0] phase_limit(input logic [CODE_W-1:0] code);
    case (code)
      2'd0:    phase_limit = 4'd0;
      2'd1:    phase_limit = 4'd3;
      default: phase_limit = 4'd15;
    endcase
  endfunction
endpackage

// File: rtl/dtimer_prescaler.sv
module dtimer_prescaler
  import dtimer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              ref_tick,
  input  logic [CODE_W-1:0] code,
  output logic              step
);
  logic [PH_W-1:0] phase_q;
  logic            at_end;

  assign at_end = (phase_q >= phase_limit(code));
  assign step   = run && ref_tick && at_end;

  always_ff @(posedge clk) begin
    if (rst || !run)
      phase_q <= '0;
    else if (ref_tick)
      phase_q <= at_end ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/dtimer_counter.sv
module dtimer_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      count <= '0;
    else if (step)
      count <= count + 1'b1;
  end
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dtimer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT1_W = 32,
  parameter int CNT2_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int HI_W  = CNT2_W - DATA_W;
  localparam int N_CH  = 2;
  localparam int PSC_W = N_CH * CODE_W;

  logic [PSC_W-1:0]  psc_q;
  logic [N_CH-1:0]   en_q;
  logic              flag_q;
  logic              mask_q;
  logic [CNT1_W-1:0] cmp_q;
  logic [HI_W-1:0]   hibuf_q;
  logic [DATA_W-1:0] rdata_q;
  logic              irq_q;

  logic [CNT1_W-1:0] cnt1;
  logic [CNT2_W-1:0] cnt2;
  logic [N_CH-1:0]   clr_w;
  logic [N_CH-1:0]   step_w;
  logic              flag_d;
  logic              mask_d;
  logic              match;
  logic [DATA_W-1:0] rd_val;

  logic wr_psc, wr_clr, wr_flg, wr_msk, wr_cmp, wr_ens, wr_enc;
  assign wr_psc = bus_we && (bus_addr == A_PSC);
  assign wr_clr = bus_we && (bus_addr == A_CLR);
  assign wr_flg = bus_we && (bus_addr == A_FLG);
  assign wr_msk = bus_we && (bus_addr == A_MSK);
  assign wr_cmp = bus_we && (bus_addr == A_CMP);
  assign wr_ens = bus_we && (bus_addr == A_ENS);
  assign wr_enc = bus_we && (bus_addr == A_ENC);

  assign clr_w = wr_clr ? bus_wdata[N_CH-1:0] : '0;

  genvar g;
  generate
    for (g = 0; g < N_CH; g++) begin : g_psc
      dtimer_prescaler u_psc (
        .clk      (clk),
        .rst      (rst),
        .run      (en_q[g] && !clr_w[g]),
        .ref_tick (ref_tick),
        .code     (psc_q[g*CODE_W +: CODE_W]),
        .step     (step_w[g])
      );
    end
  endgenerate

  dtimer_counter #(.W(CNT1_W)) u_cnt1 (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr_w[0]),
    .step  (step_w[0]),
    .count (cnt1)
  );

  dtimer_counter #(.W(CNT2_W)) u_cnt2 (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr_w[1]),
    .step  (step_w[1]),
    .count (cnt2)
  );

  assign match  = en_q[0] && (cnt1 == cmp_q);
  assign flag_d = match || (flag_q && !(wr_flg && !bus_wdata[0]));
  assign mask_d = wr_msk ? bus_wdata[0] : mask_q;

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      A_PSC:   rd_val = DATA_W'(psc_q);
      A_FLG:   rd_val = DATA_W'(flag_q);
      A_MSK:   rd_val = DATA_W'(mask_q);
      A_CMP:   rd_val = DATA_W'(cmp_q);
      A_C1:    rd_val = DATA_W'(cnt1);
      A_C2L:   rd_val = cnt2[DATA_W-1:0];
      A_C2H:   rd_val = DATA_W'(hibuf_q);
      A_ENS:   rd_val = DATA_W'(en_q);
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_q   <= '0;
      en_q    <= '0;
      flag_q  <= 1'b0;
      mask_q  <= 1'b0;
      cmp_q   <= '0;
      hibuf_q <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_psc) psc_q <= bus_wdata[PSC_W-1:0];
      if (wr_cmp) cmp_q <= bus_wdata[CNT1_W-1:0];
      if (wr_ens) en_q <= en_q | bus_wdata[N_CH-1:0];
      else if (wr_enc) en_q <= en_q & ~bus_wdata[N_CH-1:0];
      flag_q <= flag_d;
      mask_q <= mask_d;
      irq_q  <= flag_d && !mask_d;
      if (bus_re) begin
        rdata_q <= rd_val;
        if (bus_addr == A_C2L) hibuf_q <= cnt2[CNT2_W-1:DATA_W];
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk
  import dtimer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT1_W = 32,
  parameter int CNT2_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq,
  input logic              flag_q,
  input logic              mask_q,
  input logic [1:0]        en_q,
  input logic [CNT1_W-1:0] cnt1,
  input logic [CNT2_W-1:0] cnt2
);
  logic clr1_wr, clr2_wr, flg0_wr, ens0_wr;
  assign clr1_wr = bus_we && bus_addr == A_CLR && bus_wdata[0];
  assign clr2_wr = bus_we && bus_addr == A_CLR && bus_wdata[1];
  assign flg0_wr = bus_we && bus_addr == A_FLG && !bus_wdata[0];
  assign ens0_wr = bus_we && bus_addr == A_ENS && bus_wdata[0];

  p_irq_gate_r7: assert property (@(posedge clk) disable iff (rst)
    irq == (flag_q && !mask_q));

  p_stopped_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!en_q[0] && !clr1_wr) |=> $stable(cnt1));

  p_clear_zero_r3: assert property (@(posedge clk) disable iff (rst)
    clr2_wr |=> (cnt2 == '0));

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !flg0_wr) |=> flag_q);

  p_enable_set_r4: assert property (@(posedge clk) disable iff (rst)
    ens0_wr |=> en_q[0]);

  p_single_step_r2: assert property (@(posedge clk) disable iff (rst)
    !clr1_wr |=> (cnt1 == $past(cnt1) || cnt1 == CNT1_W'($past(cnt1) + 1'b1)));
endmodule

bind dual_timer dual_timer_chk #(
  .DATA_W(DATA_W), .CNT1_W(CNT1_W), .CNT2_W(CNT2_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .flag_q    (flag_q),
  .mask_q    (mask_q),
  .en_q      (en_q),
  .cnt1      (cnt1),
  .cnt2      (cnt2)
);

// File: tb/dual_timer_tb_top.sv
module dual_timer_tb_top;
  localparam int DW  = 16;
  localparam int C1W = 12;
  localparam int C2W = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ref_tick = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic          bus_re = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  always #5 clk = ~clk;

  dual_timer #(.DATA_W(DW), .CNT1_W(C1W), .CNT2_W(C2W)) dut_i (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // reference model state
  logic [3:0]     m_psc;
  logic [1:0]     m_en;
  logic           m_flag, m_mask, m_irq;
  logic [C1W-1:0] m_cmp, m_c1;
  logic [C2W-1:0] m_c2;
  logic [DW-1:0]  m_hi, m_rd;
  integer         m_ph1, m_ph2;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string cur_req = "R1";
  int lfsr = 1;
  bit rand_ref = 0;

  function automatic int divide_of(input logic [1:0] c);
    if (c == 0) return 1;
    if (c == 1) return 4;
    return 16;
  endfunction

  function automatic logic [DW-1:0] read_val(input logic [7:0] a);
    case (a)
      8'h00: return DW'(m_psc);
      8'h0C: return DW'(m_flag);
      8'h10: return DW'(m_mask);
      8'h14: return DW'(m_cmp);
      8'h18: return DW'(m_c1);
      8'h20: return m_c2[DW-1:0];
      8'h24: return m_hi;
      8'h34: return DW'(m_en);
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_psc = 0; m_en = 0; m_flag = 0; m_mask = 0; m_irq = 0;
      m_cmp = 0; m_c1 = 0; m_c2 = 0; m_hi = 0; m_rd = 0; m_ph1 = 0; m_ph2 = 0;
    end else begin
      bit c1, c2, s1, s2, match, nflag, nmask;
      logic [1:0] nen;
      logic [DW-1:0] nrd, nhi;
      c1 = bus_we && bus_addr == 8'h08 && bus_wdata[0];
      c2 = bus_we && bus_addr == 8'h08 && bus_wdata[1];
      s1 = m_en[0] && !c1 && ref_tick && (m_ph1 >= divide_of(m_psc[1:0]) - 1);
      s2 = m_en[1] && !c2 && ref_tick && (m_ph2 >= divide_of(m_psc[3:2]) - 1);
      match = m_en[0] && (m_c1 == m_cmp);
      nflag = match || (m_flag && !(bus_we && bus_addr == 8'h0C && !bus_wdata[0]));
      nmask = (bus_we && bus_addr == 8'h10) ? bus_wdata[0] : m_mask;
      nen = m_en;
      if (bus_we && bus_addr == 8'h34) nen = m_en | bus_wdata[1:0];
      if (bus_we && bus_addr == 8'h38) nen = m_en & ~bus_wdata[1:0];
      nrd = bus_re ? read_val(bus_addr) : m_rd;
      nhi = (bus_re && bus_addr == 8'h20) ? DW'(m_c2 >> DW) : m_hi;
      if (!m_en[0] || c1) m_ph1 = 0;
      else if (ref_tick) m_ph1 = s1 ? 0 : m_ph1 + 1;
      if (!m_en[1] || c2) m_ph2 = 0;
      else if (ref_tick) m_ph2 = s2 ? 0 : m_ph2 + 1;
      if (c1) m_c1 = 0; else if (s1) m_c1 = m_c1 + 1'b1;
      if (c2) m_c2 = 0; else if (s2) m_c2 = m_c2 + 1'b1;
      if (bus_we && bus_addr == 8'h00) m_psc = bus_wdata[3:0];
      if (bus_we && bus_addr == 8'h14) m_cmp = bus_wdata[C1W-1:0];
      m_en = nen; m_flag = nflag; m_mask = nmask;
      m_irq = nflag && !nmask; m_rd = nrd; m_hi = nhi;
    end
  end

  // compare outputs against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (irq !== m_irq) begin
        fails++;
        $display("FAIL %s irq: actual %0b expected %0b at %0t", cur_req, irq, m_irq, $time);
      end
      checks++;
      if (bus_rdata !== m_rd) begin
        fails++;
        $display("FAIL %s rdata: actual %h expected %h at %0t", cur_req, bus_rdata, m_rd, $time);
      end
    end
    if (rand_ref) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      ref_tick = lfsr[0] | lfsr[3];
    end
  end

  task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk); bus_addr = a; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // direct check against a value worked out from the requirements
  task automatic expect_rd(input logic [7:0] a, input logic [DW-1:0] e, input string req);
    rd(a);
    checks++;
    if (bus_rdata !== e) begin
      fails++;
      $display("FAIL %s read %h: actual %h expected %h", req, a, bus_rdata, e);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    cur_req = "R1";
    expect_rd(8'h34, 0, "R1");
    expect_rd(8'h00, 0, "R1");
    expect_rd(8'h24, 0, "R1");
    checks++;
    if (irq !== 1'b0) begin fails++; $display("FAIL R1 irq: actual %0b expected 0", irq); end

    cur_req = "R10";
    wr(8'h14, 16'h0025);
    expect_rd(8'h14, 16'h0025, "R10");
    wr(8'h00, 16'h0006);
    expect_rd(8'h00, 16'h0006, "R10");
    expect_rd(8'h3C, 0, "R10");

    cur_req = "R4";
    wr(8'h34, 16'h0001);
    expect_rd(8'h34, 16'h0001, "R4");
    wr(8'h38, 16'h0000);
    wr(8'h34, 16'h0000);
    expect_rd(8'h34, 16'h0001, "R4");
    wr(8'h34, 16'h0002);
    expect_rd(8'h34, 16'h0003, "R4");

    cur_req = "R2";
    rand_ref = 1;
    for (int c = 0; c < 4; c++) begin
      wr(8'h00, DW'(c * 5));
      idle(150);
      rd(8'h18);
      rd(8'h20);
    end

    cur_req = "R5";
    wr(8'h00, 16'h0000);
    wr(8'h08, 16'h0001);
    wr(8'h14, 16'h0030);
    idle(120);
    expect_rd(8'h0C, 1, "R5");
    cur_req = "R7";
    wr(8'h10, 16'h0001);
    idle(5);
    wr(8'h10, 16'h0000);
    idle(5);
    cur_req = "R6";
    wr(8'h0C, 16'h0001);
    expect_rd(8'h0C, 1, "R6");
    wr(8'h0C, 16'h0000);
    expect_rd(8'h0C, 0, "R6");

    cur_req = "R8";
    rand_ref = 0;
    ref_tick = 1;
    wr(8'h14, 16'h0FFF);
    wr(8'h08, 16'h0001);
    idle(4200);
    wr(8'h0C, 16'h0000);
    idle(20);
    rd(8'h18);
    wr(8'h0C, 16'h0000);

    cur_req = "R9";
    wr(8'h08, 16'h0002);
    idle(65600);
    rd(8'h20);
    expect_rd(8'h24, 16'h0001, "R9");
    rd(8'h20);

    cur_req = "R11";
    wr(8'h38, 16'h0003);
    rd(8'h18);
    idle(50);
    rd(8'h18);
    rd(8'h20);

    cur_req = "R3";
    wr(8'h08, 16'h0003);
    expect_rd(8'h18, 0, "R3");
    expect_rd(8'h20, 0, "R3");
    expect_rd(8'h08, 0, "R3");

    idle(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule